// File: doc/BRIEF.md
# Serial-Clocked Successive-Approximation Converter Controller

This block is the digital side of a 12-bit successive-approximation converter that is read over a three-wire serial port. The host lowers an active-low select line to freeze the sample and start a conversion. It then toggles a serial clock. Each rising edge of that clock resolves one result bit, and the block presents that bit on the data output straight away, most significant bit first. Two zero bits come before the result, and any number of zero bits follow it.

The block drives a trial code to an external DAC and reads back a single comparator bit, which is 1 when the held input is at or above the DAC level. A hold control tells the analog front end whether to track or hold. The data output comes with an output-enable so a pad can tri-state it. An active-low shutdown input powers the logic down. The serial inputs are asynchronous to the block clock, so they are synchronized and edge-detected on a fast system clock.

Raising select before the last bit aborts the conversion. Every raise of select, and every exit from shutdown, opens an acquisition window of a fixed number of clock cycles. A falling select inside that window is ignored.

Top module: `sar_serial_ctrl`

## Requirements
- R1: After reset, `hold`, `dout_oe`, `dout` and `done` are 0.
- R2: While the synchronized select is high, `hold` and `dout_oe` are 0. `dout` is 0 whenever `dout_oe` is 0.
- R3: A select fall accepted in the ready state raises `hold` and `dout_oe`, drives `dout` to 0 and sets `dac_code` to 0x800, the MSB trial only.
- R4: The first and second serial-clock rising edges after the start drive `dout` to 0.
- R5: Rising edges 3 to 14 present the result bits 11 down to 0 in that order. The result is straight binary: an input equal to code 0 gives 0x000, and full scale gives 0xFFF.
- R6: Each decision step keeps the current trial bit if `cmp_ge` is 1 and clears it otherwise, then sets the next lower bit. After edge 3, `dac_code` equals (sample AND 0x800) OR 0x400.
- R7: `done` pulses for exactly one clock together with the LSB step, and `result` takes the final code, which equals `dac_code` at that moment.
- R8: Rising edges after the 14th, with select still low, drive `dout` to 0 and change neither `result`, nor `dac_code`, nor `done`.
- R9: A select rise before the LSB aborts the conversion: `hold` and `dout_oe` fall, no `done` is issued, and `result` keeps its old value.
- R10: A select fall less than ACQ_CYCLES clocks after the last select rise is ignored, and `hold` stays 0 until select rises again. A conversion is accepted only after a full acquisition window.
- R11: While `shdn_n` is low, `hold` and `dout_oe` are 0 and select falls are ignored. A conversion in progress is aborted. Leaving shutdown opens a fresh acquisition window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select; falling edge starts a conversion |
| sclk | input | 1 | Serial clock; each rising edge advances one step |
| shdn_n | input | 1 | Active-low shutdown |
| cmp_ge | input | 1 | Comparator: 1 when held input >= DAC level |
| dac_code | output | 12 | Trial code to the DAC |
| hold | output | 1 | 1 = hold sample, 0 = track |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for `dout`; 0 means high impedance |
| done | output | 1 | One-clock pulse with the LSB step |
| result | output | 12 | Last completed conversion code |

## Verification
Every serial input passes through two synchronizer flops and one edge-history flop before the state register acts on it. An outputs therefore changes on the third system-clock edge after the input changes, and `done` pulses in that same cycle. The bench moves inputs on falling clock edges and holds each serial-clock level for eight system clocks. It samples outputs on a falling clock edge at the end of that hold, so every check lands well past the three-cycle latency and before the next stimulus. The `done` pulses are counted on every clock edge, so a pulse of one cycle is not missed.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_ACQ   = 3'd1,
        ST_READY = 3'd2,
        ST_BLOCK = 3'd3,
        ST_CONV  = 3'd4,
        ST_TRAIL = 3'd5
    } sar_state_e;

    localparam int IN_CS   = 0;
    localparam int IN_SCLK = 1;
    localparam int IN_SHDN = 2;
    localparam int IN_NUM  = 3;

endpackage

// File: rtl/sar_in_sync.sv
module sar_in_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] prev_o
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[STAGES-1:0], async_i[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= {(STAGES+1){RST_VAL[i]}};
            else        sh_q <= sh_d;
        end

        assign level_o[i] = sh_q[STAGES-1];
        assign prev_o[i]  = sh_q[STAGES];
    end

endmodule

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic ready_o
);

    localparam int TW = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;
    localparam logic [TW-1:0] LOAD = TW'(CYCLES - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)             cnt_d = LOAD;
        else if (cnt_q != '0)    cnt_d = cnt_q - TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LOAD;
        else        cnt_q <= cnt_d;
    end

    assign ready_o = (cnt_q == '0);

endmodule

// File: rtl/sar_bit_step.sv
module sar_bit_step #(
    parameter int W  = 12,
    parameter int XW = 4
) (
    input  logic [W-1:0]  code_i,
    input  logic [XW-1:0] idx_i,
    input  logic          cmp_ge_i,
    output logic [W-1:0]  code_o,
    output logic          bit_o
);

    always_comb begin
        code_o = code_i;
        for (int b = 0; b < W; b++) begin
            if (XW'(b) == idx_i)          code_o[b] = cmp_ge_i;
            if (XW'(b) + XW'(1) == idx_i) code_o[b] = 1'b1;
        end
        bit_o = cmp_ge_i;
    end

endmodule

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl
    import sar_pkg::*;
#(
    parameter int W           = 12,
    parameter int LEAD        = 2,
    parameter int ACQ_CYCLES  = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         sclk,
    input  logic         shdn_n,
    input  logic         cmp_ge,
    output logic [W-1:0] dac_code,
    output logic         hold,
    output logic         dout,
    output logic         dout_oe,
    output logic         done,
    output logic [W-1:0] result
);

    localparam int CW = $clog2(W + LEAD + 1);
    localparam logic [W-1:0]  MSB_ONLY = {1'b1, {(W-1){1'b0}}};
    localparam logic [CW-1:0] LAST_IDX = CW'(W + LEAD);

    typedef struct packed {
        sar_state_e    state;
        logic [CW-1:0] cnt;
        logic [W-1:0]  code;
        logic [W-1:0]  result;
        logic          busy;
        logic          dout;
        logic          done;
    } regs_t;

    localparam regs_t REGS_RST = '{
        state:  ST_ACQ,
        cnt:    '0,
        code:   '0,
        result: '0,
        busy:   1'b0,
        dout:   1'b0,
        done:   1'b0
    };

    // input synchronization and edges
    logic [IN_NUM-1:0] raw_in, lvl, prv;
    assign raw_in = {shdn_n, sclk, cs_n};

    sar_in_sync #(
        .N       (IN_NUM),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b101)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .level_o (lvl),
        .prev_o  (prv)
    );

    logic cs_s, cs_rise, cs_fall, sclk_rise, shdn_s, shdn_wake;
    assign cs_s      = lvl[IN_CS];
    assign cs_rise   = lvl[IN_CS] & ~prv[IN_CS];
    assign cs_fall   = ~lvl[IN_CS] & prv[IN_CS];
    assign sclk_rise = lvl[IN_SCLK] & ~prv[IN_SCLK];
    assign shdn_s    = lvl[IN_SHDN];
    assign shdn_wake = lvl[IN_SHDN] & ~prv[IN_SHDN];

    regs_t r_q, r_d;
    logic  acq_start, acq_ready;

    sar_acq_timer #(
        .CYCLES (ACQ_CYCLES)
    ) u_acq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (acq_start),
        .ready_o (acq_ready)
    );

    // one decision step
    logic [CW-1:0] cnt_n, idx;
    logic [W-1:0]  step_code;
    logic          step_bit;

    assign cnt_n = r_q.cnt + CW'(1);
    assign idx   = LAST_IDX - cnt_n;

    sar_bit_step #(
        .W  (W),
        .XW (CW)
    ) u_step (
        .code_i   (r_q.code),
        .idx_i    (idx),
        .cmp_ge_i (cmp_ge),
        .code_o   (step_code),
        .bit_o    (step_bit)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        acq_start = 1'b0;
        if (!shdn_s) begin
            r_d.state = ST_OFF;
            r_d.busy  = 1'b0;
            r_d.dout  = 1'b0;
            r_d.cnt   = '0;
        end else begin
            unique case (r_q.state)
                ST_OFF: begin
                    if (shdn_wake) begin
                        r_d.state = ST_ACQ;
                        acq_start = 1'b1;
                    end
                end
                ST_ACQ: begin
                    if (cs_rise) begin
                        acq_start = 1'b1;
                    end else if (acq_ready) begin
                        r_d.state = cs_s ? ST_READY : ST_BLOCK;
                    end
                end
                ST_READY: begin
                    if (cs_fall) begin
                        r_d.state = ST_CONV;
                        r_d.busy  = 1'b1;
                        r_d.dout  = 1'b0;
                        r_d.cnt   = '0;
                        r_d.code  = MSB_ONLY;
                    end
                end
                ST_BLOCK: begin
                    if (cs_rise) begin
                        r_d.state = ST_ACQ;
                        acq_start = 1'b1;
                    end
                end
                ST_CONV, ST_TRAIL: begin
                    if (cs_rise) begin
                        r_d.state = ST_ACQ;
                        r_d.busy  = 1'b0;
                        r_d.dout  = 1'b0;
                        r_d.cnt   = '0;
                        acq_start = 1'b1;
                    end else if (sclk_rise) begin
                        if (r_q.state == ST_TRAIL) begin
                            r_d.dout = 1'b0;
                        end else begin
                            r_d.cnt = cnt_n;
                            if (cnt_n <= CW'(LEAD)) begin
                                r_d.dout = 1'b0;
                            end else begin
                                r_d.code = step_code;
                                r_d.dout = step_bit;
                                if (idx == '0) begin
                                    r_d.done   = 1'b1;
                                    r_d.result = step_code;
                                    r_d.state  = ST_TRAIL;
                                end
                            end
                        end
                    end
                end
                default: begin
                    r_d.state = ST_ACQ;
                    r_d.busy  = 1'b0;
                    acq_start = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign dac_code = r_q.code;
    assign hold     = r_q.busy;
    assign dout_oe  = r_q.busy;
    assign dout     = r_q.dout;
    assign done     = r_q.done;
    assign result   = r_q.result;

endmodule

// File: rtl/sar_serial_ctrl_chk.sv
module sar_serial_ctrl_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs_lvl,
    input logic         shdn_lvl,
    input logic         hold,
    input logic         dout,
    input logic         dout_oe,
    input logic         done,
    input logic [W-1:0] dac_code,
    input logic [W-1:0] result
);

    localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

    // R2: select high forces track and high impedance
    p_cs_high_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> (!hold && !dout_oe));

    // R2: disabled output reads 0
    p_hiz_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout);

    // R3: start state
    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> (dac_code == MSB_ONLY && dout_oe && !dout));

    // R7: single-cycle done pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: result captured equals final trial code
    p_done_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result == dac_code));

    // R8: result changes only with done
    p_result_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R11: shutdown forces track and high impedance
    p_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_lvl |=> (!hold && !dout_oe));

endmodule

bind sar_serial_ctrl sar_serial_ctrl_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_lvl   (cs_s),
    .shdn_lvl (shdn_s),
    .hold     (hold),
    .dout     (dout),
    .dout_oe  (dout_oe),
    .done     (done),
    .dac_code (dac_code),
    .result   (result)
);

// File: tb/sar_serial_ctrl_tb.sv
`timescale 1ns/1ps
module sar_serial_ctrl_tb;

    localparam int W    = 12;
    localparam int ACQ  = 20;
    localparam int HALF = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic         shdn_n = 1'b1;
    logic [W-1:0] analog = '0;
    logic         cmp_ge;
    logic [W-1:0] dac_code, result;
    logic         hold, dout, dout_oe, done;

    int n_chk = 0;
    int n_fail = 0;
    int done_cnt = 0;

    always #5 clk = ~clk;

    assign cmp_ge = (analog >= dac_code);

    sar_serial_ctrl #(.W(W), .LEAD(2), .ACQ_CYCLES(ACQ), .SYNC_STAGES(2)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .shdn_n   (shdn_n),
        .cmp_ge   (cmp_ge),
        .dac_code (dac_code),
        .hold     (hold),
        .dout     (dout),
        .dout_oe  (dout_oe),
        .done     (done),
        .result   (result)
    );

    always @(posedge clk) if (rst_n && done) done_cnt <= done_cnt + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic exp_bit(input logic [W-1:0] s, input int k);
        if (k < 3 || k > 14) return 1'b0;
        return s[14-k];
    endfunction

    task automatic sclk_edge();
        sclk = 1'b1; wait_clk(HALF);
    endtask

    task automatic sclk_low();
        sclk = 1'b0; wait_clk(HALF);
    endtask

    task automatic run_conv(input logic [W-1:0] s, input int nedges);
        int start_done;
        analog = s;
        cs_n = 1'b0; wait_clk(HALF);
        check("R3 hold", hold, 1);
        check("R3 dout_oe", dout_oe, 1);
        check("R3 dout", dout, 0);
        check("R3 dac_code", dac_code, 32'h800);
        start_done = done_cnt;
        for (int k = 1; k <= nedges; k++) begin
            sclk_edge();
            if (k <= 2)       check("R4 lead zero", dout, 0);
            else if (k <= 14) check("R5 data bit", dout, exp_bit(s, k));
            else              check("R8 trail zero", dout, 0);
            if (k == 3) check("R6 trial after msb", dac_code, (s & 12'h800) | 12'h400);
            if (k == 14) begin
                check("R7 done count", done_cnt - start_done, 1);
                check("R7 result", result, s);
            end
            sclk_low();
            check("R5 dout stable on fall", dout, exp_bit(s, k));
        end
        if (nedges > 14) begin
            check("R8 no extra done", done_cnt - start_done, 1);
            check("R8 result kept", result, s);
            check("R8 dac kept", dac_code, s);
        end
        cs_n = 1'b1; wait_clk(HALF);
        check("R2 oe low", dout_oe, 0);
        check("R2 hold low", hold, 0);
        wait_clk(ACQ + 10);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        wait_clk(5);
        check("R1 hold", hold, 0);
        check("R1 dout_oe", dout_oe, 0);
        check("R1 done", done, 0);
        rst_n = 1'b1;
        wait_clk(3);
        check("R1 dout", dout, 0);
        wait_clk(ACQ + 10);

        // directed corners
        run_conv(12'h000, 15);
        run_conv(12'hFFF, 15);
        run_conv(12'h800, 18);
        run_conv(12'h7FF, 16);
        run_conv(12'h555, 20);

        // random conversions
        for (int i = 0; i < 20; i++) begin
            run_conv(W'($urandom), 15 + int'($urandom % 6));
        end

        // abort mid-conversion (R9)
        begin
            logic [W-1:0] prev_res;
            int d0;
            prev_res = result;
            d0 = done_cnt;
            analog = 12'h3C5;
            cs_n = 1'b0; wait_clk(HALF);
            for (int k = 1; k <= 6; k++) begin sclk_edge(); sclk_low(); end
            cs_n = 1'b1; wait_clk(HALF);
            check("R9 hold after abort", hold, 0);
            check("R9 oe after abort", dout_oe, 0);
            check("R9 no done", done_cnt - d0, 0);
            check("R9 result kept", result, prev_res);
            // R10: fall inside acquisition window ignored
            cs_n = 1'b0; wait_clk(HALF);
            check("R10 hold ignored", hold, 0);
            wait_clk(ACQ + 10);
            check("R10 still tracking", hold, 0);
            sclk_edge();
            check("R10 oe stays low", dout_oe, 0);
            sclk_low();
            cs_n = 1'b1; wait_clk(ACQ + 10);
            run_conv(12'h3C5, 15);
        end

        // shutdown (R11)
        begin
            int d0;
            shdn_n = 1'b0; wait_clk(HALF);
            check("R11 hold off", hold, 0);
            check("R11 oe off", dout_oe, 0);
            cs_n = 1'b0; wait_clk(HALF);
            check("R11 start ignored", hold, 0);
            cs_n = 1'b1; wait_clk(HALF);
            shdn_n = 1'b1; wait_clk(ACQ + 10);
            analog = 12'hA0F;
            d0 = done_cnt;
            cs_n = 1'b0; wait_clk(HALF);
            check("R11 conv after wake", hold, 1);
            for (int k = 1; k <= 5; k++) begin sclk_edge(); sclk_low(); end
            shdn_n = 1'b0; wait_clk(HALF);
            check("R11 abort hold", hold, 0);
            check("R11 abort oe", dout_oe, 0);
            check("R11 abort no done", done_cnt - d0, 0);
            cs_n = 1'b1; wait_clk(HALF);
            shdn_n = 1'b1; wait_clk(5);
            cs_n = 1'b0; wait_clk(HALF);
            check("R11 wake window ignores start", hold, 0);
            cs_n = 1'b1; wait_clk(ACQ + 10);
            run_conv(12'hA0F, 15);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule